// File: doc/BRIEF.md
# Supply Threshold Monitor with Edge-Triggered Line

This block watches an unsigned supply code from an external converter. It compares the code against one of eight thresholds, chosen by a 3-bit level field. The result is a level flag that is high while the supply sits strictly below the chosen threshold. The thresholds form a parameter table.

The flag passes through a two-stage synchronizer and then into an edge-detecting line. Software can make rising edges, falling edges, or both qualify. A qualifying edge does two separate things, each with its own enable:

- It can set a sticky pending flag, which drives the interrupt request. Software clears this flag by writing one.
- It can emit a one-cycle event pulse.

A configuration write loads all settings in one cycle. During that cycle, every line enable is treated as cleared, so no edge can qualify while settings change. The monitor is forced inactive while its enable is low or while the system is in standby.

Top module: `supply_mon_top`

## Requirements
- R1: With the monitor active, `below_flag` is 1 exactly when `supply_code` is strictly less than the threshold picked by `cfg_level`. The default table gives 100 + 16*L for level L (0..7).
- R2: A change of `supply_code` reaches `below_flag` on the third rising clock edge after it is applied (one compare register plus two synchronizer stages).
- R3: A 0-to-1 change of `below_flag` qualifies only when `cfg_rise_en` is set. A 1-to-0 change qualifies only when `cfg_fall_en` is set. A change whose direction is disabled leaves `irq` and `evt_pulse` untouched.
- R4: With both edge enables set, changes in either direction qualify.
- R5: A qualifying edge sets the pending flag (`irq`) only when `cfg_irq_en` is 1. It drives `evt_pulse` high for exactly one cycle only when `cfg_evt_en` is 1. `evt_pulse` appears one cycle after `below_flag` changes.
- R6: `irq` stays set until a cycle with `pend_clr` = 1 clears it. If a qualifying edge falls in that same cycle, `irq` stays 1.
- R7: In a cycle with `cfg_wr` = 1, no edge qualifies. The written settings govern from the next cycle on.
- R8: While the monitor enable is 0, the compare result is 0 and no edge qualifies, including the falling edge caused by disabling.
- R9: While `standby` is 1, the monitor behaves as when disabled. It resumes normally when `standby` returns to 0.
- R10: After reset, `below_flag`, `irq` and `evt_pulse` are 0 and all configuration bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| supply_code | input | CODE_W | Unsigned digitized supply level |
| standby | input | 1 | System in deepest low-power state; monitor stopped |
| cfg_wr | input | 1 | Load all configuration fields below |
| cfg_mon_en | input | 1 | Monitor enable |
| cfg_level | input | LVL_W | Threshold select |
| cfg_irq_en | input | 1 | Interrupt path enable |
| cfg_evt_en | input | 1 | Event path enable |
| cfg_rise_en | input | 1 | Rising-edge sensitivity |
| cfg_fall_en | input | 1 | Falling-edge sensitivity |
| pend_clr | input | 1 | Write-one-to-clear strobe for the pending flag |
| below_flag | output | 1 | Synchronized comparison flag |
| irq | output | 1 | Pending flag / interrupt request |
| evt_pulse | output | 1 | One-cycle event pulse |

## Verification
The level sweep places the code on each threshold and one count below it. This separates the strict less-than comparison from an off-by-one or inverted one, and it catches a wrong table index. Rise-only, fall-only and both-edge configurations each see a low-going and a high-going supply, which shows that each edge direction is routed to its own enable. Interrupt-only and event-only settings separate the two output paths. Edges placed in the exact cycle of a configuration write, and of a pending clear, probe the two collision rules. Disable and standby are each entered while the flag is high, so a leaked falling edge would be visible.

// File: rtl/supply_mon_pkg.sv
package supply_mon_pkg;

   typedef struct packed {
      logic mon_en;
      logic irq_en;
      logic evt_en;
      logic rise_en;
      logic fall_en;
   } line_cfg_t;

   localparam line_cfg_t LINE_CFG_RESET = '{default: 1'b0};

endpackage

// File: rtl/supply_mon_cmp.sv
module supply_mon_cmp #(
   parameter int CODE_W = 8,
   parameter int LVL_W  = 3,
   parameter logic [(1<<LVL_W)-1:0][CODE_W-1:0] THRESH = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic [LVL_W-1:0]  level,
   input  logic [CODE_W-1:0] code,
   output logic              below_q
);

   logic [CODE_W-1:0] thr_sel;

   always_comb thr_sel = THRESH[level];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) below_q <= 1'b0;
      else        below_q <= active && (code < thr_sel);
   end

endmodule

// File: rtl/supply_mon_sync.sv
module supply_mon_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   logic [STAGES-1:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[STAGES-2:0], d};
   end

   assign q = sh_q[STAGES-1];

endmodule

// File: rtl/supply_mon_line.sv
module supply_mon_line (
   input  logic clk,
   input  logic rst_n,
   input  logic flag,
   input  logic active,
   input  logic cfg_wr,
   input  logic rise_en,
   input  logic fall_en,
   input  logic irq_en,
   input  logic evt_en,
   input  logic pend_clr,
   output logic pend_q,
   output logic evt_q
);

   logic prev_q;
   logic rise_hit, fall_hit, hit;

   always_comb begin
      rise_hit = flag & ~prev_q & rise_en;
      fall_hit = ~flag & prev_q & fall_en;
      // settings count as cleared during a configuration write
      hit      = (rise_hit | fall_hit) & active & ~cfg_wr;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         pend_q <= 1'b0;
         evt_q  <= 1'b0;
      end else begin
         prev_q <= flag;
         pend_q <= (pend_q & ~pend_clr) | (hit & irq_en);
         evt_q  <= hit & evt_en;
      end
   end

endmodule

// File: rtl/supply_mon_top.sv
module supply_mon_top
   import supply_mon_pkg::*;
#(
   parameter int CODE_W      = 8,
   parameter int LVL_W       = 3,
   parameter int SYNC_STAGES = 2,
   parameter logic [(1<<LVL_W)-1:0][CODE_W-1:0] THRESH =
      {8'd212, 8'd196, 8'd180, 8'd164, 8'd148, 8'd132, 8'd116, 8'd100}
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] supply_code,
   input  logic              standby,
   input  logic              cfg_wr,
   input  logic              cfg_mon_en,
   input  logic [LVL_W-1:0]  cfg_level,
   input  logic              cfg_irq_en,
   input  logic              cfg_evt_en,
   input  logic              cfg_rise_en,
   input  logic              cfg_fall_en,
   input  logic              pend_clr,
   output logic              below_flag,
   output logic              irq,
   output logic              evt_pulse
);

   localparam int NUM_LVL = 1 << LVL_W;

   generate
      if (CODE_W < 1) begin : g_bad_code
         $error("CODE_W must be at least 1");
      end
      if (LVL_W < 1 || NUM_LVL > 64) begin : g_bad_lvl
         $error("LVL_W out of range");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   line_cfg_t        cfg_q;
   logic [LVL_W-1:0] level_q;
   logic             active;
   logic             raw_flag;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q   <= LINE_CFG_RESET;
         level_q <= '0;
      end else if (cfg_wr) begin
         cfg_q   <= '{mon_en: cfg_mon_en, irq_en: cfg_irq_en, evt_en: cfg_evt_en,
                      rise_en: cfg_rise_en, fall_en: cfg_fall_en};
         level_q <= cfg_level;
      end
   end

   always_comb active = cfg_q.mon_en & ~standby;

   supply_mon_cmp #(
      .CODE_W (CODE_W),
      .LVL_W  (LVL_W),
      .THRESH (THRESH)
   ) cmp_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .active  (active),
      .level   (level_q),
      .code    (supply_code),
      .below_q (raw_flag)
   );

   supply_mon_sync #(
      .STAGES (SYNC_STAGES)
   ) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_flag),
      .q     (below_flag)
   );

   supply_mon_line line_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .flag     (below_flag),
      .active   (active),
      .cfg_wr   (cfg_wr),
      .rise_en  (cfg_q.rise_en),
      .fall_en  (cfg_q.fall_en),
      .irq_en   (cfg_q.irq_en),
      .evt_en   (cfg_q.evt_en),
      .pend_clr (pend_clr),
      .pend_q   (irq),
      .evt_q    (evt_pulse)
   );

endmodule

// File: rtl/supply_mon_chk.sv
module supply_mon_chk
   import supply_mon_pkg::*;
(
   input logic      clk,
   input logic      rst_n,
   input logic      standby,
   input logic      cfg_wr,
   input logic      pend_clr,
   input logic      active,
   input logic      raw_flag,
   input line_cfg_t cfg_q,
   input logic      irq,
   input logic      evt_pulse
);

   // R6: pending is sticky without a clear
   p_pend_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !pend_clr) |=> irq);

   // R6: clear takes effect when no set is possible
   p_pend_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && pend_clr && !cfg_q.irq_en) |=> !irq);

   // R5: pending only rises through an enabled interrupt path
   p_irq_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(cfg_q.irq_en && active && !cfg_wr));

   // R5: event only through an enabled event path
   p_evt_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
      evt_pulse |-> $past(cfg_q.evt_en && active && !cfg_wr));

   // R7: nothing qualifies in a write cycle
   p_cfg_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr |=> (!evt_pulse && !$rose(irq)));

   // R8: disabled monitor gives a zero compare result
   p_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_q.mon_en |=> !raw_flag);

   // R9: standby stops the monitor
   p_standby_r9: assert property (@(posedge clk) disable iff (!rst_n)
      standby |=> !raw_flag);

endmodule

bind supply_mon_top supply_mon_chk chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .standby   (standby),
   .cfg_wr    (cfg_wr),
   .pend_clr  (pend_clr),
   .active    (active),
   .raw_flag  (raw_flag),
   .cfg_q     (cfg_q),
   .irq       (irq),
   .evt_pulse (evt_pulse)
);

// File: tb/supply_mon_top_tb.sv
`timescale 1ns/1ps
module supply_mon_top_tb_top;

   localparam int CODE_W = 8;
   localparam int LVL_W  = 3;
   localparam int WD_CYC = 100000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [CODE_W-1:0] supply_code = 8'd255;
   logic              standby = 1'b0;
   logic              cfg_wr = 1'b0;
   logic              cfg_mon_en = 1'b0;
   logic [LVL_W-1:0]  cfg_level = '0;
   logic              cfg_irq_en = 1'b0;
   logic              cfg_evt_en = 1'b0;
   logic              cfg_rise_en = 1'b0;
   logic              cfg_fall_en = 1'b0;
   logic              pend_clr = 1'b0;
   logic              below_flag, irq, evt_pulse;

   int  n_checks = 0;
   int  n_errors = 0;
   bit  done = 1'b0;

   always #2 clk = ~clk;

   supply_mon_top dut_i (
      .clk (clk), .rst_n (rst_n), .supply_code (supply_code), .standby (standby),
      .cfg_wr (cfg_wr), .cfg_mon_en (cfg_mon_en), .cfg_level (cfg_level),
      .cfg_irq_en (cfg_irq_en), .cfg_evt_en (cfg_evt_en),
      .cfg_rise_en (cfg_rise_en), .cfg_fall_en (cfg_fall_en),
      .pend_clr (pend_clr), .below_flag (below_flag), .irq (irq),
      .evt_pulse (evt_pulse)
   );

   task automatic check(string req, string what, logic act, logic exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s %s: actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr_cfg(logic m, logic [LVL_W-1:0] l, logic ie, logic ee, logic re, logic fe);
      cfg_mon_en = m; cfg_level = l; cfg_irq_en = ie; cfg_evt_en = ee;
      cfg_rise_en = re; cfg_fall_en = fe; cfg_wr = 1'b1;
      step(1);
      cfg_wr = 1'b0;
   endtask

   task automatic clr_pend();
      pend_clr = 1'b1;
      step(1);
      pend_clr = 1'b0;
   endtask

   task automatic t_reset();
      step(3);
      rst_n = 1'b1;
      step(1);
      check("R10", "flag", below_flag, 1'b0);
      check("R10", "irq", irq, 1'b0);
      check("R10", "evt", evt_pulse, 1'b0);
      supply_code = 8'd0;
      step(4);
      check("R10", "monitor off after reset", below_flag, 1'b0);
      supply_code = 8'd255;
   endtask

   task automatic t_levels();
      for (int lv = 0; lv < 8; lv++) begin
         int thr = 100 + 16 * lv;
         wr_cfg(1'b1, LVL_W'(lv), 1'b0, 1'b0, 1'b0, 1'b0);
         supply_code = CODE_W'(thr);
         step(3);
         check("R1", "at threshold", below_flag, 1'b0);
         supply_code = CODE_W'(thr - 1);
         step(2);
         check("R2", "not yet after two edges", below_flag, 1'b0);
         step(1);
         check("R1", "one below threshold", below_flag, 1'b1);
      end
      supply_code = 8'd255;
      step(4);
   endtask

   task automatic t_rising();
      wr_cfg(1'b1, 3'd0, 1'b1, 1'b1, 1'b1, 1'b0);
      step(4);
      clr_pend();
      supply_code = 8'd0;
      step(3);
      check("R2", "flag visible", below_flag, 1'b1);
      check("R5", "no event before edge", evt_pulse, 1'b0);
      step(1);
      check("R3", "rise irq", irq, 1'b1);
      check("R3", "rise evt", evt_pulse, 1'b1);
      step(1);
      check("R5", "evt single cycle", evt_pulse, 1'b0);
      check("R6", "irq held", irq, 1'b1);
      clr_pend();
      check("R6", "irq cleared", irq, 1'b0);
      supply_code = 8'd255;
      step(4);
      check("R3", "fall ignored irq", irq, 1'b0);
      check("R3", "fall ignored evt", evt_pulse, 1'b0);
   endtask

   task automatic t_falling();
      wr_cfg(1'b1, 3'd0, 1'b1, 1'b1, 1'b0, 1'b1);
      supply_code = 8'd0;
      step(4);
      check("R3", "rise ignored irq", irq, 1'b0);
      check("R3", "rise ignored evt", evt_pulse, 1'b0);
      supply_code = 8'd255;
      step(4);
      check("R3", "fall irq", irq, 1'b1);
      check("R3", "fall evt", evt_pulse, 1'b1);
      clr_pend();
   endtask

   task automatic t_both();
      wr_cfg(1'b1, 3'd0, 1'b1, 1'b1, 1'b1, 1'b1);
      supply_code = 8'd0;
      step(4);
      check("R4", "rise irq", irq, 1'b1);
      check("R4", "rise evt", evt_pulse, 1'b1);
      clr_pend();
      supply_code = 8'd255;
      step(4);
      check("R4", "fall irq", irq, 1'b1);
      check("R4", "fall evt", evt_pulse, 1'b1);
      clr_pend();
   endtask

   task automatic t_paths();
      wr_cfg(1'b1, 3'd0, 1'b0, 1'b1, 1'b1, 1'b1);
      supply_code = 8'd0;
      step(4);
      check("R5", "event only: evt", evt_pulse, 1'b1);
      check("R5", "event only: irq", irq, 1'b0);
      wr_cfg(1'b1, 3'd0, 1'b1, 1'b0, 1'b1, 1'b1);
      supply_code = 8'd255;
      step(4);
      check("R5", "irq only: evt", evt_pulse, 1'b0);
      check("R5", "irq only: irq", irq, 1'b1);
      clr_pend();
   endtask

   task automatic t_w1c();
      wr_cfg(1'b1, 3'd0, 1'b1, 1'b1, 1'b1, 1'b1);
      supply_code = 8'd0;
      step(4);
      check("R6", "set", irq, 1'b1);
      supply_code = 8'd255;
      step(3);
      pend_clr = 1'b1;
      step(1);
      pend_clr = 1'b0;
      check("R6", "set wins over clear", irq, 1'b1);
      check("R6", "collision evt", evt_pulse, 1'b1);
      clr_pend();
      check("R6", "plain clear", irq, 1'b0);
   endtask

   task automatic t_cfgwr();
      supply_code = 8'd0;
      step(3);
      cfg_wr = 1'b1;
      step(1);
      cfg_wr = 1'b0;
      check("R7", "edge in write cycle irq", irq, 1'b0);
      check("R7", "edge in write cycle evt", evt_pulse, 1'b0);
      supply_code = 8'd255;
      step(4);
      check("R7", "settings active after write", irq, 1'b1);
      check("R7", "event after write", evt_pulse, 1'b1);
      clr_pend();
   endtask

   task automatic t_disable();
      supply_code = 8'd0;
      step(4);
      clr_pend();
      check("R8", "flag high before disable", below_flag, 1'b1);
      wr_cfg(1'b0, 3'd0, 1'b1, 1'b1, 1'b1, 1'b1);
      for (int i = 0; i < 6; i++) begin
         step(1);
         check("R8", "no event while disabled", evt_pulse, 1'b0);
      end
      check("R8", "flag forced low", below_flag, 1'b0);
      check("R8", "no irq from disable", irq, 1'b0);
      supply_code = 8'd255;
      wr_cfg(1'b1, 3'd0, 1'b1, 1'b1, 1'b1, 1'b1);
      step(5);
   endtask

   task automatic t_standby();
      supply_code = 8'd0;
      step(4);
      clr_pend();
      standby = 1'b1;
      for (int i = 0; i < 6; i++) begin
         step(1);
         check("R9", "no event in standby", evt_pulse, 1'b0);
      end
      check("R9", "flag low in standby", below_flag, 1'b0);
      check("R9", "no irq in standby", irq, 1'b0);
      standby = 1'b0;
      step(3);
      check("R9", "flag resumes", below_flag, 1'b1);
      step(1);
      check("R9", "edge after resume", irq, 1'b1);
      clr_pend();
   endtask

   initial begin
      t_reset();
      t_levels();
      t_rising();
      t_falling();
      t_both();
      t_paths();
      t_w1c();
      t_cfgwr();
      t_disable();
      t_standby();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      #(WD_CYC * 4);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

endmodule